// File: doc/BRIEF.md
# Pulse Width and Period Limit Checker

This block measures an external waveform with a 16-bit up-counter that advances on a count-enable tick. It does this round after round. In each round it records two values in a capture register. The first is the duration of the active phase, which is the pulse width. The second is the duration of a whole cycle, which is the period. Each recorded value is compared against a pair of programmable bounds, one upper and one lower. When a value falls outside its bounds, a sticky status flag is set. A flag raises an interrupt request only if its enable bit is set.

A polarity setting chooses which waveform edge opens a round. A stop setting freezes the measurement as soon as any violation is recorded. The measurement stays frozen until software clears the flags. The waveform input must already be synchronized to `clk`. The tick comes from a prescaler outside this block. The configuration inputs are meant to be driven straight from a register file. Flags are cleared by a write strobe that carries a write-zero-to-clear data word.

Top module: `pw_period_monitor`

## Requirements
- R1: While `cfg_run` is 0, `count` reads 0 one cycle later. Waveform edges start no round, and `capture` does not change.
- R2: While running and not frozen, `count` rises by one at each clock edge where `tick` is 1. It keeps its value when `tick` is 0.
- R3: With `cfg_fall_first` at 0, the opening edge is rising and the width-closing edge is falling. With `cfg_fall_first` at 1, these polarities are swapped. The opening edge clears `count` to 0.
- R4: The width-closing edge copies `count` into `capture`. The width-over flag (`flags[0]`) is set if the copied value is strictly greater than `lim_w_hi`. The width-under flag (`flags[1]`) is set if it is strictly less than `lim_w_lo`. Both comparisons are unsigned. If the waveform holds its active level for H clock cycles with `tick` held at 1, the captured value is H-1.
- R5: The next opening-polarity edge copies `count` into `capture` as the period. The period-over flag (`flags[2]`) is set if the value is strictly greater than `lim_p_hi`. The period-under flag (`flags[3]`) is set if it is strictly less than `lim_p_lo`. For a cycle of P clocks with `tick` at 1, the captured value is P-1. A value equal to a limit sets no flag.
- R6: The period-closing edge also clears `count` to 0 and begins the next width measurement at once.
- R7: With `cfg_stop_en` at 1 and any flag set, `count` and the edge sequence hold, and edges are ignored. In the first cycle after the freeze condition ends, `count` returns to 0. From then on, counting resumes and the next round waits for a fresh opening edge.
- R8: When `flag_wr` is 1, each flag whose `flag_wdata` bit is 0 is cleared, and a data bit of 1 leaves its flag unchanged. A set event in the same cycle as a clear wins, and the flag stays at 1.
- R9: `count` stops at 0xFFFF instead of wrapping, so an overlong width or period still reads as 0xFFFF.
- R10: `irq[i]` is 1 exactly while `flags[i]` and `irq_en[i]` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_in | input | 1 | Measured waveform, already synchronized |
| tick | input | 1 | Count enable from the prescaler |
| cfg_run | input | 1 | 1 = measuring, 0 = counter held at 0 |
| cfg_fall_first | input | 1 | 1 = rounds open on a falling edge |
| cfg_stop_en | input | 1 | Freeze measurement while any flag is set |
| lim_w_hi | input | 16 | Width upper limit |
| lim_w_lo | input | 16 | Width lower limit |
| lim_p_hi | input | 16 | Period upper limit |
| lim_p_lo | input | 16 | Period lower limit |
| irq_en | input | 4 | Per-flag interrupt enables |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 4 | Flag write data, 0 bits clear |
| capture | output | 16 | Last captured width or period |
| flags | output | 4 | Status flags: [0] width over, [1] width under, [2] period over, [3] period under |
| irq | output | 4 | Per-flag interrupt requests |
| count | output | 16 | Current counter value |

## Verification
The properties assume three things about the inputs. `wave_in` is stable from one clock to the next, and any change in it counts as an edge. `flag_wdata` is meaningful only while `flag_wr` is high. Configuration may change in any cycle. When the run bit drops, the counter rule applies from the next cycle, with no settling window. The stimulus stays within these assumptions in two ways. It changes the waveform and the configuration only at falling clock edges. It also parks the block with `cfg_run` low before loading new limits or a new polarity, so no round is left half-measured across a configuration change.

// File: rtl/pw_period_pkg.sv
// Package: shared types and flag indices for the width/period monitor.
// Assumes four limit flags in a fixed order that software decodes.
package pw_period_pkg;
    localparam int NFLAG    = 4;
    localparam int FLG_WOVR = 0;
    localparam int FLG_WUND = 1;
    localparam int FLG_POVR = 2;
    localparam int FLG_PUND = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WIDTH  = 2'd1,
        PH_PERIOD = 2'd2
    } phase_e;
endpackage

// File: rtl/pw_edge_seq.sv
// Edge sequencer: detects edges on the synchronized waveform and walks
// the three-edge round (open, width close, period close).
// Assumes wave_in is already synchronous to clk.
module pw_edge_seq
    import pw_period_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wave_in,
    input  logic fall_first,
    input  logic run,
    input  logic halted,
    input  logic resume,
    output logic clr_evt,
    output logic cap_w,
    output logic cap_p
);
    logic   wave_d;
    logic   rise, fall, open_edge, close_edge;
    phase_e phase_q, phase_d;

    // Purpose: remember the previous waveform level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_d <= 1'b0;
        else        wave_d <= wave_in;
    end

    assign rise       = wave_in & ~wave_d;
    assign fall       = ~wave_in & wave_d;
    assign open_edge  = fall_first ? fall : rise;
    assign close_edge = fall_first ? rise : fall;

    // Purpose: decide the next phase and the capture/clear events.
    always_comb begin
        phase_d = phase_q;
        clr_evt = 1'b0;
        cap_w   = 1'b0;
        cap_p   = 1'b0;
        if (!run || resume) begin
            phase_d = PH_IDLE;
        end else if (!halted) begin
            unique case (phase_q)
                PH_IDLE: if (open_edge) begin
                    clr_evt = 1'b1;
                    phase_d = PH_WIDTH;
                end
                PH_WIDTH: if (close_edge) begin
                    cap_w   = 1'b1;
                    phase_d = PH_PERIOD;
                end
                PH_PERIOD: if (open_edge) begin
                    cap_p   = 1'b1;
                    clr_evt = 1'b1;
                    phase_d = PH_WIDTH;
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Purpose: register the round phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/pw_sat_counter.sv
// Saturating measurement counter: clears, holds or advances on tick.
// Assumes clr/resume are single-cycle events from the sequencer and top.
module pw_sat_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          halted,
    input  logic          resume,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CMAX = '1;

    // Purpose: apply run/freeze/clear priority, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)               count <= '0;
        else if (!run)            count <= '0;
        else if (halted)          count <= count;
        else if (resume || clr)   count <= '0;
        else if (tick && count != CMAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/pw_flag_bank.sv
// Flag bank: compares a captured value with its limits, keeps sticky
// flags with write-zero-to-clear, and masks them into interrupt requests.
// Assumes cap_w and cap_p never fire in the same cycle.
module pw_flag_bank
    import pw_period_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_w,
    input  logic             cap_p,
    input  logic [CW-1:0]    sample,
    input  logic [CW-1:0]    lim_w_hi,
    input  logic [CW-1:0]    lim_w_lo,
    input  logic [CW-1:0]    lim_p_hi,
    input  logic [CW-1:0]    lim_p_lo,
    input  logic             wr,
    input  logic [NFLAG-1:0] wdata,
    input  logic [NFLAG-1:0] ien,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] irq
);
    logic [NFLAG-1:0] set_vec;

    // Purpose: strict unsigned limit comparisons on the capturing edge.
    always_comb begin
        set_vec           = '0;
        set_vec[FLG_WOVR] = cap_w && (sample > lim_w_hi);
        set_vec[FLG_WUND] = cap_w && (sample < lim_w_lo);
        set_vec[FLG_POVR] = cap_p && (sample > lim_p_hi);
        set_vec[FLG_PUND] = cap_p && (sample < lim_p_lo);
    end

    // Purpose: sticky flags, set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < NFLAG; i++) begin
                if (set_vec[i])              flags[i] <= 1'b1;
                else if (wr && !wdata[i])    flags[i] <= 1'b0;
            end
        end
    end

    assign irq = flags & ien;
endmodule

// File: rtl/pw_period_monitor.sv
// Top: pulse width and period limit checker. Ties the edge sequencer,
// the saturating counter and the flag bank together, owns the capture
// register and the stop-on-violation freeze.
// Assumes wave_in is synchronized and tick comes from an external prescaler.
module pw_period_monitor
    import pw_period_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wave_in,
    input  logic             tick,
    input  logic             cfg_run,
    input  logic             cfg_fall_first,
    input  logic             cfg_stop_en,
    input  logic [CW-1:0]    lim_w_hi,
    input  logic [CW-1:0]    lim_w_lo,
    input  logic [CW-1:0]    lim_p_hi,
    input  logic [CW-1:0]    lim_p_lo,
    input  logic [NFLAG-1:0] irq_en,
    input  logic             flag_wr,
    input  logic [NFLAG-1:0] flag_wdata,
    output logic [CW-1:0]    capture,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] irq,
    output logic [CW-1:0]    count
);
    logic halted, halted_q, resume;
    logic clr_evt, cap_w, cap_p;

    assign halted = cfg_stop_en && (|flags);
    assign resume = halted_q && !halted;

    // Purpose: remember the freeze state to spot the cycle it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) halted_q <= 1'b0;
        else        halted_q <= halted;
    end

    pw_edge_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wave_in    (wave_in),
        .fall_first (cfg_fall_first),
        .run        (cfg_run),
        .halted     (halted),
        .resume     (resume),
        .clr_evt    (clr_evt),
        .cap_w      (cap_w),
        .cap_p      (cap_p)
    );

    pw_sat_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_run),
        .halted (halted),
        .resume (resume),
        .clr    (clr_evt),
        .tick   (tick),
        .count  (count)
    );

    // Purpose: latch the counter on a width or period capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)             capture <= '0;
        else if (cap_w || cap_p) capture <= count;
    end

    pw_flag_bank #(.CW(CW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_w    (cap_w),
        .cap_p    (cap_p),
        .sample   (count),
        .lim_w_hi (lim_w_hi),
        .lim_w_lo (lim_w_lo),
        .lim_p_hi (lim_p_hi),
        .lim_p_lo (lim_p_lo),
        .wr       (flag_wr),
        .wdata    (flag_wdata),
        .ien      (irq_en),
        .flags    (flags),
        .irq      (irq)
    );
endmodule

// File: rtl/pw_period_monitor_sva.sv
// Checker: temporal properties of the width/period monitor, bound to the top.
// Assumes it sees the top's ports plus the internal freeze and event nets.
module pw_period_monitor_sva #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          cfg_run,
    input logic          flag_wr,
    input logic [3:0]    flag_wdata,
    input logic [CW-1:0] capture,
    input logic [3:0]    flags,
    input logic [CW-1:0] count,
    input logic          halted,
    input logic          resume,
    input logic          clr_evt,
    input logic          cap_w,
    input logic          cap_p
);
    localparam logic [CW-1:0] CMAX = '1;
    logic [3:0] clr_mask;
    assign clr_mask = flag_wr ? ~flag_wdata : 4'b0000;

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |=> (count == '0));

    // R3
    open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (count == '0));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_run && halted) |=> $stable(count));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_run && tick && !halted && !resume && !clr_evt && count == CMAX)
        |=> (count == CMAX));

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == 4'b0000));

    // R4
    capture_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(capture) |-> $past(cap_w || cap_p));

    // R5
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags)) != 4'b0000) |-> $past(cap_w || cap_p));
endmodule

bind pw_period_monitor pw_period_monitor_sva #(.CW(CW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cfg_run    (cfg_run),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .capture    (capture),
    .flags      (flags),
    .count      (count),
    .halted     (halted),
    .resume     (resume),
    .clr_evt    (clr_evt),
    .cap_w      (cap_w),
    .cap_p      (cap_p)
);

// File: tb/test_pw_period_monitor.sv
// Bench: vector table of waveform rounds and limits, then directed tests.
module test_pw_period_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wave_in = 1'b0;
    logic        tick = 1'b1;
    logic        cfg_run = 1'b0;
    logic        cfg_fall_first = 1'b0;
    logic        cfg_stop_en = 1'b0;
    logic [15:0] lim_w_hi = 16'd20, lim_w_lo = 16'd5;
    logic [15:0] lim_p_hi = 16'd30, lim_p_lo = 16'd10;
    logic [3:0]  irq_en = 4'b0000;
    logic        flag_wr = 1'b0;
    logic [3:0]  flag_wdata = 4'b1111;
    logic [15:0] capture, count;
    logic [3:0]  flags, irq;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pw_period_monitor i_pw_period_monitor (
        .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .tick(tick),
        .cfg_run(cfg_run), .cfg_fall_first(cfg_fall_first),
        .cfg_stop_en(cfg_stop_en), .lim_w_hi(lim_w_hi), .lim_w_lo(lim_w_lo),
        .lim_p_hi(lim_p_hi), .lim_p_lo(lim_p_lo), .irq_en(irq_en),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .capture(capture),
        .flags(flags), .irq(irq), .count(count)
    );

    typedef struct packed {
        logic        ff;
        logic [15:0] h, l, wh, wl, ph, pl;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd10, 16'd6,  16'd20, 16'd5, 16'd30, 16'd10},
        '{1'b0, 16'd4,  16'd4,  16'd20, 16'd5, 16'd30, 16'd10},
        '{1'b1, 16'd25, 16'd10, 16'd20, 16'd5, 16'd30, 16'd10},
        '{1'b0, 16'd21, 16'd10, 16'd20, 16'd5, 16'd30, 16'd10},
        '{1'b1, 16'd6,  16'd5,  16'd20, 16'd5, 16'd30, 16'd10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        flag_wr = 1'b1; flag_wdata = 4'b0000;
        cyc(1);
        flag_wr = 1'b0; flag_wdata = 4'b1111;
    endtask

    // Park, configure, and start with the waveform at its idle level.
    task automatic start(input logic ff, input logic stop);
        cfg_run = 1'b0; cfg_fall_first = ff; cfg_stop_en = stop;
        wave_in = ff;
        clear_all();
        cyc(1);
        cfg_run = 1'b1;
        cyc(3);
    endtask

    initial begin
        #(20 * 190000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("reset count", count, 0);
        chk("reset capture", capture, 0);
        chk("reset flags", flags, 0);
        chk("reset irq", irq, 0);

        // R1: stopped counter ignores ticks and edges
        for (int k = 0; k < 6; k++) begin
            wave_in = ~wave_in;
            cyc(2);
        end
        chk("R1 count held", count, 0);
        chk("R1 capture unchanged", capture, 0);

        // Vector table: R3 R4 R5 R6 R10
        irq_en = 4'b1111;
        for (int v = 0; v < NV; v++) begin
            logic [15:0] w, p;
            logic [3:0]  ew, ef;
            lim_w_hi = VECS[v].wh; lim_w_lo = VECS[v].wl;
            lim_p_hi = VECS[v].ph; lim_p_lo = VECS[v].pl;
            w = VECS[v].h - 16'd1;
            p = VECS[v].h + VECS[v].l - 16'd1;
            ew = {2'b00, (w < VECS[v].wl), (w > VECS[v].wh)};
            ef = {(p < VECS[v].pl), (p > VECS[v].ph), 2'b00} | ew;
            start(VECS[v].ff, 1'b0);
            wave_in = ~VECS[v].ff;
            cyc(32'(VECS[v].h));
            wave_in = VECS[v].ff;
            cyc(1);
            chk("R4 width capture", capture, w);
            chk("R4 width flags", flags, ew);
            chk("R10 irq follows flags", irq, ew);
            cyc(32'(VECS[v].l) - 1);
            wave_in = ~VECS[v].ff;
            cyc(1);
            chk("R5 period capture", capture, p);
            chk("R5 period flags", flags, ef);
            chk("R6 count cleared", count, 0);
            cyc(32'(VECS[v].h) - 1);
            wave_in = VECS[v].ff;
            cyc(1);
            chk("R6 next width", capture, w);
        end

        // R2: tick gating
        lim_w_hi = 16'd20; lim_w_lo = 16'd0; lim_p_hi = 16'hFFFF; lim_p_lo = 16'd0;
        start(1'b0, 1'b0);
        tick = 1'b0;
        wave_in = 1'b1;
        cyc(5);
        chk("R2 no tick no count", count, 0);
        tick = 1'b1;
        cyc(3);
        chk("R2 ticks counted", count, 3);

        // R8 + R10: set beats same-cycle clear; write-one keeps; masked irq
        irq_en = 4'b0000;
        start(1'b0, 1'b0);
        wave_in = 1'b1;
        cyc(30);
        wave_in = 1'b0; flag_wr = 1'b1; flag_wdata = 4'b0000;
        cyc(1);
        flag_wr = 1'b0; flag_wdata = 4'b1111;
        chk("R8 set wins over clear", flags, 4'b0001);
        chk("R10 masked irq", irq, 0);
        irq_en = 4'b0001;
        #1;
        chk("R10 enabled irq", irq, 4'b0001);
        flag_wr = 1'b1; flag_wdata = 4'b1111;
        cyc(1);
        chk("R8 write one keeps", flags, 4'b0001);
        flag_wdata = 4'b1110;
        cyc(1);
        flag_wr = 1'b0; flag_wdata = 4'b1111;
        chk("R8 write zero clears", flags, 4'b0000);

        // R7: stop on violation, freeze, resume after clear
        start(1'b0, 1'b1);
        wave_in = 1'b1;
        cyc(30);
        wave_in = 1'b0;
        cyc(1);
        chk("R7 violation flagged", flags, 4'b0001);
        chk("R7 count at edge", count, 30);
        cyc(1);
        wave_in = 1'b1;
        cyc(2);
        wave_in = 1'b0;
        cyc(2);
        chk("R7 count frozen", count, 30);
        chk("R7 edges ignored", capture, 29);
        flag_wr = 1'b1; flag_wdata = 4'b1110;
        cyc(1);
        flag_wr = 1'b0; flag_wdata = 4'b1111;
        chk("R7 still held on clear", count, 30);
        cyc(1);
        chk("R7 cleared on resume", count, 0);
        cyc(1);
        chk("R7 counting resumed", count, 1);

        // R9: saturation on an overlong pulse
        start(1'b0, 1'b0);
        wave_in = 1'b1;
        cyc(65540);
        chk("R9 count saturates", count, 16'hFFFF);
        wave_in = 1'b0;
        cyc(1);
        chk("R9 saturated capture", capture, 16'hFFFF);
        chk("R9 overflow reported", flags, 4'b0001);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule